// File: doc/BRIEF.md
# Edge-Qualified Event Counter

This block is a free-running up-counter with two ways of advancing. In timer mode it adds one on every clock cycle in which the count enable is high. In event mode it counts transitions on one of several external inputs. Each external input passes through a two-stage synchronizer. A per-input history flop then compares the current synchronized level with the previous one. The counter steps only when the transition found on the selected input is of the kind the control word asks for: rising, falling, or either.

A four-bit control word sets the behaviour. Bits 1:0 pick the mode and bits 3:2 pick the input. The count is driven straight from a register. It wraps silently at its width. An input change is reflected in the count three clock edges after it is first captured. An external signal is counted faithfully only when each of its high and low levels lasts at least two clock periods.

Top module: `evcnt_top`

## Requirements
- R1: A synchronous active-high `rst` clears `count` to zero and clears all synchronizer and history state, so inputs held low through reset produce no count afterwards.
- R2: With `ctrl[1:0]` = 00 (timer mode), `count` increases by one after every rising clock edge at which `en` is high.
- R3: With `ctrl[1:0]` = 01, `count` increases by one for each low-to-high transition of the selected input, and falling transitions are not counted.
- R4: With `ctrl[1:0]` = 10, `count` increases by one for each high-to-low transition of the selected input, and rising transitions are not counted.
- R5: With `ctrl[1:0]` = 11, every transition of the selected input, in either direction, increases `count` by one.
- R6: `ctrl[3:2]` holds the index of the input used as the count source, as an unsigned number in the range 0 to 3 into `cap_in`. Activity on the inputs that are not selected leaves `count` unchanged.
- R7: While `en` is low, `count` holds its value. Transitions that happen while `en` is low are never counted later.
- R8: A level change on `cap_in` that is set up before clock edge k shows in `count` after edge k+2, and not before.
- R9: Changing `ctrl[3:2]` to an input whose level is steady adds no count, even when its level differs from the level of the input selected before.
- R10: `count` wraps from all ones to zero without any other indication.
- R11: When each high and low level lasts two clock periods, every transition is counted exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable; low holds the count |
| ctrl | input | 4 | [1:0] mode (00 timer, 01 rise, 10 fall, 11 both), [3:2] input select |
| cap_in | input | 4 | Asynchronous external event inputs |
| count | output | CNT_W (32) | Registered counter value |

## Verification
A fault in the synchronizer chain or in the edge history shows up as a count that moves one cycle early or late, or that moves by the wrong amount, within three edges of an input change. A bench that samples every cycle catches it at once. If the history is shared between inputs instead of kept per input, a spurious step appears on the cycle after a select change. A stuck qualifier or enable path makes `count` drift away from the modelled value on the first cycle in which the mode or the enable should have mattered.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'b00,
    MODE_RISE  = 2'b01,
    MODE_FALL  = 2'b10,
    MODE_BOTH  = 2'b11
  } cnt_mode_e;

  localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/evcnt_sync.sv
module evcnt_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= '0;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/evcnt_edge.sv
module evcnt_edge #(
  parameter int unsigned N_CH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] lvl,
  output logic [N_CH-1:0] rise,
  output logic [N_CH-1:0] fall
);

  logic [N_CH-1:0] hist_q;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= lvl;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign rise[c] =  lvl[c] & ~hist_q[c];
    assign fall[c] = ~lvl[c] &  hist_q[c];
  end

endmodule

// File: rtl/evcnt_qual.sv
module evcnt_qual
  import evcnt_pkg::*;
#(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned SEL_W = 2
) (
  input  cnt_mode_e        mode,
  input  logic [SEL_W-1:0] sel,
  input  logic [N_CH-1:0]  rise,
  input  logic [N_CH-1:0]  fall,
  output logic             tick
);

  localparam int unsigned N_PAD = 1 << SEL_W;

  logic [N_PAD-1:0] rise_pad, fall_pad;
  logic             r_sel, f_sel;

  assign rise_pad = N_PAD'(rise);
  assign fall_pad = N_PAD'(fall);
  assign r_sel    = rise_pad[sel];
  assign f_sel    = fall_pad[sel];

  always_comb begin
    unique case (mode)
      MODE_TIMER: tick = 1'b1;
      MODE_RISE:  tick = r_sel;
      MODE_FALL:  tick = f_sel;
      MODE_BOTH:  tick = r_sel | f_sel;
      default:    tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/evcnt_core.sv
module evcnt_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst)              count <= '0;
    else if (en && tick)  count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/evcnt_top.sv
module evcnt_top
  import evcnt_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned N_CH     = 4,
  parameter int unsigned SYNC_STG = 2,
  localparam int unsigned SEL_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int unsigned CTRL_W  = MODE_W + SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [N_CH-1:0]   cap_in,
  output logic [CNT_W-1:0]  count
);

  cnt_mode_e        mode;
  logic [SEL_W-1:0] sel;
  logic [N_CH-1:0]  lvl_sync, rise, fall;
  logic             tick;

  assign mode = cnt_mode_e'(ctrl[MODE_W-1:0]);
  assign sel  = ctrl[CTRL_W-1:MODE_W];

  evcnt_sync #(.WIDTH(N_CH), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d_async(cap_in), .d_sync(lvl_sync)
  );

  evcnt_edge #(.N_CH(N_CH)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl_sync), .rise(rise), .fall(fall)
  );

  evcnt_qual #(.N_CH(N_CH), .SEL_W(SEL_W)) u_qual (
    .mode(mode), .sel(sel), .rise(rise), .fall(fall), .tick(tick)
  );

  evcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .count(count)
  );

endmodule

// File: rtl/evcnt_chk.sv
module evcnt_chk #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned CTRL_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [CTRL_W-1:0] ctrl,
  input logic              tick,
  input logic [CNT_W-1:0]  count
);

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> count == '0);

  p_timer_tick_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl[1:0] == 2'b00 |-> tick);

  p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
    en && tick |=> count == CNT_W'($past(count) + CNT_W'(1)));

  p_quiet_hold_r6: assert property (@(posedge clk) disable iff (rst)
    en && !tick |=> $stable(count));

  p_enable_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));

  p_wrap_zero_r10: assert property (@(posedge clk) disable iff (rst)
    en && tick && (count == {CNT_W{1'b1}}) |=> count == '0);

endmodule

bind evcnt_top evcnt_chk #(.CNT_W(CNT_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .ctrl(ctrl), .tick(tick), .count(count)
);

// File: tb/sim_evcnt_top.sv
`timescale 1ns/1ps
module sim_evcnt_top;

  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b0;
  logic [3:0]    ctrl = 4'd0;
  logic [3:0]    cap_in = 4'd0;
  logic [CW-1:0] count;

  int n_chk = 0;
  int n_bad = 0;
  string ph = "R1";
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  evcnt_top #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .en(en), .ctrl(ctrl), .cap_in(cap_in), .count(count)
  );

  // independent reference: two-stage synchronizer, per-input history
  logic [3:0]    m_s1 = '0, m_s2 = '0, m_hist = '0;
  logic [CW-1:0] m_cnt = '0;

  function automatic bit want_step(input logic [1:0] md, input logic now, input logic was);
    case (md)
      2'b00: return 1'b1;
      2'b01: return now & ~was;
      2'b10: return ~now & was;
      default: return now ^ was;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_hist <= '0; m_cnt <= '0;
    end else begin
      if (en && want_step(ctrl[1:0], m_s2[ctrl[3:2]], m_hist[ctrl[3:2]]))
        m_cnt <= m_cnt + CW'(1);
      m_hist <= m_s2;
      m_s2   <= m_s1;
      m_s1   <= cap_in;
    end
  end

  task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: count actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (model_on && !rst) check(ph, count, m_cnt);

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // random input generator keeping each level at least two cycles
  int hold [4] = '{9, 9, 9, 9};
  task automatic rnd_caps(input logic [3:0] allow);
    for (int c = 0; c < 4; c++) begin
      if (allow[c] && hold[c] >= 2 && $urandom_range(0, 1)) begin
        cap_in[c] = ~cap_in[c]; hold[c] = 1;
      end else hold[c]++;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  logic [CW-1:0] base;

  initial begin
    void'($urandom(32'h5eed_1234));
    cyc(3);
    rst = 1'b0;
    cyc(4);
    check("R1 reset", count, '0);
    model_on = 1'b1;

    // R8 latency and R3 rising
    ph = "R3"; ctrl = 4'b00_01; en = 1'b1;
    cap_in[0] = 1'b1;              // set up before edge k
    cyc(1); check("R8 after k", count, '0);
    cyc(1); check("R8 after k+1", count, '0);
    cyc(1); check("R8 after k+2", count, CW'(1));
    cap_in[0] = 1'b0; cyc(5);
    check("R3 fall ignored", count, CW'(1));

    // R4 falling
    ph = "R4"; ctrl = 4'b00_10; base = count;
    cap_in[0] = 1'b1; cyc(4); check("R4 rise ignored", count, base);
    cap_in[0] = 1'b0; cyc(4); check("R4 fall counted", count, base + CW'(1));

    // R5 and R11: toggle every two cycles
    ph = "R5"; ctrl = 4'b00_11; base = count;
    for (int t = 0; t < 20; t++) begin cap_in[0] = ~cap_in[0]; cyc(2); end
    cyc(3);
    check("R11 every edge once", count, base + CW'(20));

    // R6 unselected inputs
    ph = "R6"; base = count;
    for (int t = 0; t < 20; t++) begin cap_in[3:1] = ~cap_in[3:1]; cyc(2); end
    cyc(3);
    check("R6 other inputs ignored", count, base);

    // R9 switch select to steady input at a different level
    ph = "R9"; cap_in = 4'b0010; cyc(5); base = count;
    ctrl = 4'b01_11; cyc(5);
    check("R9 select switch", count, base);

    // R7 enable low drops edges
    ph = "R7"; en = 1'b0; base = count;
    for (int t = 0; t < 6; t++) begin cap_in[1] = ~cap_in[1]; cyc(2); end
    cyc(3); en = 1'b1; cyc(5);
    check("R7 held and dropped", count, base);

    // R2 timer
    ph = "R2"; ctrl = 4'b00_00; base = count; cyc(10);
    check("R2 timer steps", count, base + CW'(10));

    // random mix
    ph = "R3-5 random";
    for (int t = 0; t < 4000; t++) begin
      if (t % 40 == 0) ctrl = 4'($urandom_range(0, 15));
      en = ($urandom_range(0, 9) != 0);
      rnd_caps(4'hF);
      cyc(1);
    end

    // R10 wrap in timer mode
    ph = "R10"; ctrl = 4'b00_00; en = 1'b1;
    rst = 1'b1; cyc(2); rst = 1'b0;
    cyc((1 << CW) - 1);
    check("R10 all ones", count, {CW{1'b1}});
    cyc(1);
    check("R10 wrap to zero", count, '0);

    model_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule